// File: doc/BRIEF.md
# Paired carryless 16x64 multiplier

This block multiplies, for two independent lanes, a 16-bit polynomial by a 64-bit polynomial over GF(2). Each lane yields an 80-bit product, and a third output carries the XOR of both lane products. That combined value is the one a CRC folding step consumes. The individual lane products are brought out as well, so that each one can be checked on its own.

Each lane is built only from 8x8-to-16 carryless byte multipliers. The wide operand's bytes are split into an even-indexed set and an odd-indexed set. Each set is multiplied by the low byte and by the high byte of the narrow operand. The two groups whose terms fall on odd byte ranks are XORed before placement. Because the terms in each group then sit on disjoint 16-bit slots, the three groups are placed by concatenation, at offsets of 0, 8 and 16 bits, and not by variable shifts.

The results are registered. A single valid strobe marks input operands that should be captured.

Top module: `clmul16x64_pair`

## Requirements
- R1: While rst_ni is low, and after its release until the first capture, valid_o is 0 and all three product outputs are 0.
- R2: valid_o in each cycle equals valid_i sampled at the previous rising clock edge.
- R3: One cycle after valid_i is high, prod0_o equals the carryless product of a0_i and b0_i as they were sampled with valid_i.
- R4: One cycle after valid_i is high, prod1_o equals the carryless product of a1_i and b1_i as they were sampled with valid_i.
- R5: prod_xor_o equals the bitwise XOR of the carryless products of lane 0 and lane 1, with the same timing as R3.
- R6: A cycle with valid_i low leaves all three product outputs unchanged, whatever values the operand inputs carry.
- R7: Bit i of every operand is the coefficient of x^i, with byte 0 least significant. Bit k of every product is the coefficient of x^k, so a=2^i and b=2^j give a product with only bit i+j set.
- R8: A zero operand on either side of a lane gives an all-zero product for that lane.
- R9: Bit 79 of every product is always 0. The all-ones times all-ones product sets bit 78 and bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands are valid and are captured |
| a0_i | input | 16 | Lane 0 narrow operand |
| b0_i | input | 64 | Lane 0 wide operand |
| a1_i | input | 16 | Lane 1 narrow operand |
| b1_i | input | 64 | Lane 1 wide operand |
| valid_o | output | 1 | Products are valid |
| prod0_o | output | 80 | Lane 0 product |
| prod1_o | output | 80 | Lane 1 product |
| prod_xor_o | output | 80 | XOR of the lane products |

## Verification
The block holds no state beyond its output register, so any internal fault shows up in the product bits one cycle after the operands are captured. A byte multiplier that is wrong, or a group placed at the wrong rank, gives wrong bits at a fixed offset. Single-set-bit operands expose this directly, because they step the one live bit across every byte boundary of both operands. A missing merge of the two odd-rank groups loses terms only when both bytes of the narrow operand are nonzero, so random operands with full-width values are compared every cycle. A stale or ungated capture shows as a change in the products during a cycle in which valid_i is low.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  localparam int BYTE_W = 8;
  localparam int PP_W   = 2 * BYTE_W;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [PP_W-1:0]   pp_t;
endpackage

// File: rtl/clmul_byte.sv
module clmul_byte
  import clmul_pkg::*;
(
  input  byte_t a_i,
  input  byte_t b_i,
  output pp_t   p_o
);
  pp_t row [BYTE_W];

  for (genvar i = 0; i < BYTE_W; i++) begin : g_row
    assign row[i] = a_i[i] ? (pp_t'(b_i) << i) : '0;
  end

  always_comb begin
    p_o = '0;
    for (int i = 0; i < BYTE_W; i++) p_o = p_o ^ row[i];
  end
endmodule

// File: rtl/clmul_lane.sv
module clmul_lane
  import clmul_pkg::*;
#(
  parameter int WIDE_BYTES = 8
) (
  input  logic [PP_W-1:0]                  a_i,
  input  logic [WIDE_BYTES*BYTE_W-1:0]     b_i,
  output logic [WIDE_BYTES*BYTE_W+PP_W-1:0] p_o
);
  localparam int HALF   = WIDE_BYTES / 2;
  localparam int CAT_W  = HALF * PP_W;
  localparam int PROD_W = WIDE_BYTES * BYTE_W + PP_W;

  byte_t w_lo, w_hi;
  assign w_lo = a_i[BYTE_W-1:0];
  assign w_hi = a_i[PP_W-1:BYTE_W];

  logic [CAT_W-1:0] even_cat;  // w_lo * even bytes, ranks 2m
  logic [CAT_W-1:0] odd_cat;   // merged cross terms, ranks 2m+1
  logic [CAT_W-1:0] top_cat;   // w_hi * odd bytes, ranks 2m+2

  for (genvar m = 0; m < HALF; m++) begin : g_pair
    byte_t x_even, x_odd;
    pp_t   p_le, p_lo, p_he, p_ho;
    assign x_even = b_i[(2*m)*BYTE_W +: BYTE_W];
    assign x_odd  = b_i[(2*m+1)*BYTE_W +: BYTE_W];

    clmul_byte u_le (.a_i(w_lo), .b_i(x_even), .p_o(p_le));
    clmul_byte u_lo (.a_i(w_lo), .b_i(x_odd),  .p_o(p_lo));
    clmul_byte u_he (.a_i(w_hi), .b_i(x_even), .p_o(p_he));
    clmul_byte u_ho (.a_i(w_hi), .b_i(x_odd),  .p_o(p_ho));

    assign even_cat[m*PP_W +: PP_W] = p_le;
    assign odd_cat[m*PP_W +: PP_W]  = p_lo ^ p_he;
    assign top_cat[m*PP_W +: PP_W]  = p_ho;
  end

  logic [PROD_W-1:0] t_even, t_odd, t_top;
  assign t_even = {{PP_W{1'b0}}, even_cat};
  assign t_odd  = {{BYTE_W{1'b0}}, odd_cat, {BYTE_W{1'b0}}};
  assign t_top  = {top_cat, {PP_W{1'b0}}};
  assign p_o    = t_even ^ t_odd ^ t_top;
endmodule

// File: rtl/clmul16x64_pair.sv
module clmul16x64_pair
  import clmul_pkg::*;
#(
  parameter int WIDE_BYTES = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              valid_i,
  input  logic [PP_W-1:0]                   a0_i,
  input  logic [WIDE_BYTES*BYTE_W-1:0]      b0_i,
  input  logic [PP_W-1:0]                   a1_i,
  input  logic [WIDE_BYTES*BYTE_W-1:0]      b1_i,
  output logic                              valid_o,
  output logic [WIDE_BYTES*BYTE_W+PP_W-1:0] prod0_o,
  output logic [WIDE_BYTES*BYTE_W+PP_W-1:0] prod1_o,
  output logic [WIDE_BYTES*BYTE_W+PP_W-1:0] prod_xor_o
);
  localparam int PROD_W = WIDE_BYTES * BYTE_W + PP_W;

  logic [PROD_W-1:0] p0, p1;

  clmul_lane #(.WIDE_BYTES(WIDE_BYTES)) u_lane0 (.a_i(a0_i), .b_i(b0_i), .p_o(p0));
  clmul_lane #(.WIDE_BYTES(WIDE_BYTES)) u_lane1 (.a_i(a1_i), .b_i(b1_i), .p_o(p1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      prod0_o    <= '0;
      prod1_o    <= '0;
      prod_xor_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        prod0_o    <= p0;
        prod1_o    <= p1;
        prod_xor_o <= p0 ^ p1;
      end
    end
  end
endmodule

// File: rtl/clmul16x64_pair_chk.sv
module clmul16x64_pair_chk
  import clmul_pkg::*;
#(
  parameter int WIDE_BYTES = 8
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              valid_i,
  input logic [PP_W-1:0]                   a0_i,
  input logic [WIDE_BYTES*BYTE_W-1:0]      b0_i,
  input logic [PP_W-1:0]                   a1_i,
  input logic [WIDE_BYTES*BYTE_W-1:0]      b1_i,
  input logic                              valid_o,
  input logic [WIDE_BYTES*BYTE_W+PP_W-1:0] prod0_o,
  input logic [WIDE_BYTES*BYTE_W+PP_W-1:0] prod1_o,
  input logic [WIDE_BYTES*BYTE_W+PP_W-1:0] prod_xor_o
);
  localparam int WIDE_W = WIDE_BYTES * BYTE_W;
  localparam int PROD_W = WIDE_W + PP_W;

  function automatic logic [PROD_W-1:0] serial_mul(logic [PP_W-1:0] a, logic [WIDE_W-1:0] b);
    logic [PROD_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < PP_W; i++)
      if (a[i]) acc = acc ^ (PROD_W'(b) << i);
    return acc;
  endfunction

  a_r1_reset_clear: assert property (@(posedge clk_i) !rst_ni |=> (!valid_o && prod0_o == '0 && prod1_o == '0 && prod_xor_o == '0));
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> valid_o);
  a_r2_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> !valid_o);
  a_r3_lane0_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> prod0_o == serial_mul($past(a0_i), $past(b0_i)));
  a_r4_lane1_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> prod1_o == serial_mul($past(a1_i), $past(b1_i)));
  a_r5_xor_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> prod_xor_o == (serial_mul($past(a0_i), $past(b0_i)) ^ serial_mul($past(a1_i), $past(b1_i))));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(prod0_o) && $stable(prod1_o) && $stable(prod_xor_o)));
  a_r9_top_bit_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prod0_o[PROD_W-1] && !prod1_o[PROD_W-1] && !prod_xor_o[PROD_W-1]);
endmodule

bind clmul16x64_pair clmul16x64_pair_chk #(.WIDE_BYTES(WIDE_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .a0_i(a0_i), .b0_i(b0_i), .a1_i(a1_i), .b1_i(b1_i),
  .valid_o(valid_o), .prod0_o(prod0_o), .prod1_o(prod1_o), .prod_xor_o(prod_xor_o)
);

// File: tb/clmul16x64_pair_tb.sv
`timescale 1ns/1ps
module clmul16x64_pair_tb;
  localparam int PROD_W = 80;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] a0_i = '0, a1_i = '0;
  logic [63:0] b0_i = '0, b1_i = '0;
  logic        valid_o;
  logic [79:0] prod0_o, prod1_o, prod_xor_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        exp_v = 1'b0;
  logic [79:0] exp0 = '0, exp1 = '0;

  always #5 clk_i = ~clk_i;

  clmul16x64_pair u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .a0_i(a0_i), .b0_i(b0_i), .a1_i(a1_i), .b1_i(b1_i),
    .valid_o(valid_o), .prod0_o(prod0_o), .prod1_o(prod1_o), .prod_xor_o(prod_xor_o)
  );

  function automatic logic [79:0] ref_mul(logic [15:0] a, logic [63:0] b);
    logic [79:0] r;
    logic [79:0] sh;
    r = '0;
    sh = {16'b0, b};
    for (int i = 0; i < 16; i++) begin
      if (a[i]) r ^= sh;
      sh = sh << 1;
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, compare just after the next posedge
  task automatic step(string tag, logic v, logic [15:0] a0, logic [63:0] b0,
                      logic [15:0] a1, logic [63:0] b1);
    @(negedge clk_i);
    valid_i = v; a0_i = a0; b0_i = b0; a1_i = a1; b1_i = b1;
    if (v) begin
      exp0 = ref_mul(a0, b0);
      exp1 = ref_mul(a1, b1);
    end
    exp_v = v;
    @(posedge clk_i);
    #1;
    chk({tag, " R2 valid"}, {79'b0, valid_o}, {79'b0, exp_v});
    chk({tag, " R3 lane0"}, prod0_o, exp0);
    chk({tag, " R4 lane1"}, prod1_o, exp1);
    chk({tag, " R5 xor"}, prod_xor_o, exp0 ^ exp1);
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 reset valid", {79'b0, valid_o}, 80'd0);
    chk("R1 reset prod0", prod0_o, 80'd0);
    chk("R1 reset prod_xor", prod_xor_o, 80'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 after release prod1", prod1_o, 80'd0);

    // R7 single bits across all positions
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 64; j += 7)
        step("R7 single", 1'b1, 16'(1) << i, 64'(1) << j, 16'(1) << (15 - i), 64'(1) << (63 - j));
    for (int i = 0; i < 16; i++) begin
      step("R7 one bit", 1'b1, 16'(1) << i, 64'(1) << (4 * i + 3), 16'h0001, 64'h8000_0000_0000_0000);
      chk("R7 bit position", prod0_o, 80'(1) << (5 * i + 3));
    end

    // R8 zero operands
    step("R8 zero", 1'b1, 16'h0, {64{1'b1}}, 16'hffff, 64'h0);
    chk("R8 lane0 zero", prod0_o, 80'd0);
    chk("R8 lane1 zero", prod1_o, 80'd0);

    // R9 all ones
    step("R9 ones", 1'b1, 16'hffff, {64{1'b1}}, 16'hffff, {64{1'b1}});
    chk("R9 bit79 clear", {79'b0, prod0_o[79]}, 80'd0);
    chk("R9 bit78 set", {79'b0, prod0_o[78]}, 80'd1);
    chk("R9 bit0 set", {79'b0, prod0_o[0]}, 80'd1);
    chk("R5 equal lanes cancel", prod_xor_o, 80'd0);

    // R6 hold with changing operands
    for (int k = 0; k < 8; k++)
      step("R6 hold", 1'b0, 16'($urandom), {$urandom, $urandom}, 16'($urandom), {$urandom, $urandom});

    // random with intermittent valid
    for (int k = 0; k < 2000; k++)
      step("rand", ($urandom % 4) != 0, 16'($urandom), {$urandom, $urandom},
           16'($urandom), {$urandom, $urandom});

    // back-to-back then idle
    step("R2 b2b", 1'b1, 16'h1234, 64'hdead_beef_0bad_f00d, 16'hff00, 64'h0123_4567_89ab_cdef);
    step("R2 b2b", 1'b1, 16'h00ff, 64'hfedc_ba98_7654_3210, 16'h8001, 64'haaaa_5555_aaaa_5555);
    step("R6 idle", 1'b0, 16'hffff, {64{1'b1}}, 16'hffff, {64{1'b1}});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule